// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block counts active edges of an external pulse input in a 16-bit register and, at the same time, supplies the advance tick for a separate timer counter. The tick comes either from the timer prescaler or from the accumulator. From the accumulator it can be taken on every counted edge, on each wrap of the count's low byte (one tick per 256 edges), or on each wrap of the full count (one tick per 65536 edges). The pulse input passes through a two-stage synchronizer before edge detection. A control bit chooses whether rising or falling edges are counted.

Software reaches the block through a small register port. It holds a control register, a flag register and the count register. There are two flags. The edge flag records that an edge was counted. The overflow flag records a wrap of the 16-bit count, or a wrap pulse from an external 8-bit accumulator. Each flag drives an interrupt request through its own enable. Flags are cleared either by writing ones to them, or, in fast-clear mode, by any access to the count register. The block also forwards a divide-by-64 reference tick from the prescaler, and it does so only while the timer is enabled.

Top module: `pulse_acc_clksel`

## Requirements
- R1: After reset, the control register (address 0), the flag register (address 1) and the count register (address 2) all read 0.
- R2: While the enable bit (control bit 5) is 1, the count increases by one for each active edge of `pulse_in`, wrapping 0xFFFF to 0x0000. Control bit 4 = 1 selects rising edges and 0 selects falling edges. While bit 5 is 0, edges leave the count unchanged.
- R3: A counted edge sets the edge flag (flag bit 0). `irq_edge` is high exactly when the edge flag is 1 and control bit 0 is 1.
- R4: A count wrap from 0xFFFF to 0x0000 sets the overflow flag (flag bit 1). A high cycle on `ext8_wrap` also sets it.
- R5: With control bit 6 at 0, writing 1 to a flag bit clears that flag and writing 0 leaves it unchanged. Flag register bits 15..2 always read 0.
- R6: With control bit 6 at 1, any read or write of the count register clears both flags, and writes to the flag register have no effect.
- R7: `irq_ovf` is high exactly when the overflow flag is 1 and control bit 1 is 1.
- R8: With the enable bit at 1, the clock select field (control bits 3..2) drives `tmr_tick` as follows: 00 gives `presc_tick`, 01 gives one tick per counted edge, 10 gives one tick per wrap of the count's low 8 bits, and 11 gives one tick per wrap of the full 16-bit count.
- R9: While the enable bit is 0, `tmr_tick` equals `presc_tick` whatever the clock select value.
- R10: A write to the clock select field governs `tmr_tick` from the cycle that follows the write edge. There is no wait for any counter boundary.
- R11: `ref64_tick` repeats `presc64_tick` one cycle later while `tmr_en` is 1, and stays 0 while `tmr_en` is 0.
- R12: A write to the count register loads the written value. When it coincides with a counted edge, the load wins and no increment or wrap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register address: 0 control, 1 flags, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| pulse_in | input | 1 | External pulse input, asynchronous |
| presc_tick | input | 1 | Timer prescaler tick |
| presc64_tick | input | 1 | Divide-by-64 tick from the prescaler |
| tmr_en | input | 1 | Timer enable |
| ext8_wrap | input | 1 | Wrap pulse from an external 8-bit accumulator |
| tmr_tick | output | 1 | Advance tick for the timer counter |
| ref64_tick | output | 1 | Gated divide-by-64 reference tick |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Edge interrupt request |

## Verification
Pulse bursts of random length, with random high and low widths and random polarity, are sent from random preloaded counts. The number of ticks under each select value is compared with the count of edges and wraps worked out arithmetically. This separates the edge, low-byte and full-wrap taps, and it exposes a wrong polarity or an off-by-one in the tap positions. Random prescaler patterns with the accumulator disabled confirm the forced fallback. Directed cases cover the following:
- a load that meets an edge in the same cycle;
- a select change while the prescaler is held high;
- the two flag-clearing modes;
- the external wrap input;
- the timer-enable gating of the reference tick.

// File: rtl/pacc_pkg.sv
// Shared definitions for the pulse accumulator: register addresses,
// clock-select encoding and the packed control register layout.
package pacc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd2;

    localparam int FLG_EDGE = 0;
    localparam int FLG_OVF  = 1;

    typedef enum logic [1:0] {
        SEL_PRESC    = 2'b00,
        SEL_EDGE     = 2'b01,
        SEL_DIV_LO   = 2'b10,
        SEL_DIV_FULL = 2'b11
    } clk_sel_e;

    // Bit 6 fast_clr, 5 acc_en, 4 rise_sel, 3..2 clk_sel, 1 ovf_ie, 0 edge_ie
    typedef struct packed {
        logic     fast_clr;
        logic     acc_en;
        logic     rise_sel;
        clk_sel_e clk_sel;
        logic     ovf_ie;
        logic     edge_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_edge_sync.sv
// Synchronizes the asynchronous pulse input through STAGES flip-flops and
// emits a one-cycle strobe on the selected edge polarity.
// Assumes each input level is held for at least two clock cycles.
module pacc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              cur;

    generate
        if (STAGES == 1) begin : g_one
            // Capture the raw input in a single stage
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pulse_in;
            end
        end else begin : g_chain
            // Shift the raw input along the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pulse_in};
            end
        end
    endgenerate

    assign cur = sync_q[STAGES-1];

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= cur;
    end

    // Pick the active edge according to the polarity bit
    always_comb begin
        if (rise_sel) edge_hit = cur & ~last_q;
        else          edge_hit = ~cur & last_q;
    end
endmodule

// File: rtl/pacc_counter.sv
// Accumulator count register with software load and wrap taps.
// A load has priority over an increment; taps fire only on real increments.
module pacc_counter #(
    parameter int CNT_W = 16,
    parameter int TAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap_tap,
    output logic             wrap_full
);
    logic step;

    assign step      = inc & ~load;
    assign wrap_tap  = step & (&count[TAP_W-1:0]);
    assign wrap_full = step & (&count);

    // Load, increment or hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= count + 1'b1;
    end
endmodule

// File: rtl/pacc_tick_sel.sv
// Chooses the timer counter tick. The prescaler tick is forced whenever the
// accumulator is disabled. This is combinational so select changes act at once.
module pacc_tick_sel
    import pacc_pkg::*;
(
    input  logic     acc_en,
    input  clk_sel_e clk_sel,
    input  logic     presc_tick,
    input  logic     edge_tick,
    input  logic     tap_tick,
    input  logic     full_tick,
    output logic     tmr_tick
);
    // Route the selected source to the timer
    always_comb begin
        if (!acc_en) begin
            tmr_tick = presc_tick;
        end else begin
            unique case (clk_sel)
                SEL_PRESC:    tmr_tick = presc_tick;
                SEL_EDGE:     tmr_tick = edge_tick;
                SEL_DIV_LO:   tmr_tick = tap_tick;
                SEL_DIV_FULL: tmr_tick = full_tick;
                default:      tmr_tick = presc_tick;
            endcase
        end
    end
endmodule

// File: rtl/pulse_acc_clksel.sv
// Top level of the pulse accumulator. It holds the register file, the flags,
// the interrupt requests and the gated reference tick, and it instantiates
// the synchronizer, the counter and the tick selector.
// Assumes a single-cycle register access with bus_sel held for one cycle.
module pulse_acc_clksel
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TAP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pulse_in,
    input  logic              presc_tick,
    input  logic              presc64_tick,
    input  logic              tmr_en,
    input  logic              ext8_wrap,
    output logic              tmr_tick,
    output logic              ref64_tick,
    output logic              irq_ovf,
    output logic              irq_edge
);
    ctrl_t             ctrl_q;
    logic              edge_q;
    logic              ovf_q;
    logic [CNT_W-1:0]  count_q;
    logic              edge_hit;
    logic              acc_inc;
    logic              cnt_load;
    logic              wrap_tap;
    logic              wrap_full;
    logic              wr_ctrl;
    logic              wr_flag;
    logic              cnt_access;
    logic              fast_hit;
    logic              clr_edge;
    logic              clr_ovf;

    // Decode the register accesses
    always_comb begin
        wr_ctrl    = bus_sel & bus_wr & (bus_addr == ADR_CTRL);
        wr_flag    = bus_sel & bus_wr & (bus_addr == ADR_FLAG) & ~ctrl_q.fast_clr;
        cnt_load   = bus_sel & bus_wr & (bus_addr == ADR_CNT);
        cnt_access = bus_sel & (bus_wr | bus_rd) & (bus_addr == ADR_CNT);
        fast_hit   = ctrl_q.fast_clr & cnt_access;
        clr_edge   = fast_hit | (wr_flag & bus_wdata[FLG_EDGE]);
        clr_ovf    = fast_hit | (wr_flag & bus_wdata[FLG_OVF]);
    end

    // Hold the control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    pacc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .rise_sel (ctrl_q.rise_sel),
        .edge_hit (edge_hit)
    );

    assign acc_inc = edge_hit & ctrl_q.acc_en;

    pacc_counter #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (acc_inc),
        .load      (cnt_load),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .count     (count_q),
        .wrap_tap  (wrap_tap),
        .wrap_full (wrap_full)
    );

    // Update the flags; a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            edge_q <= acc_inc | (edge_q & ~clr_edge);
            ovf_q  <= wrap_full | ext8_wrap | (ovf_q & ~clr_ovf);
        end
    end

    pacc_tick_sel u_sel (
        .acc_en     (ctrl_q.acc_en),
        .clk_sel    (ctrl_q.clk_sel),
        .presc_tick (presc_tick),
        .edge_tick  (acc_inc & ~cnt_load),
        .tap_tick   (wrap_tap),
        .full_tick  (wrap_full),
        .tmr_tick   (tmr_tick)
    );

    // Pass the divide-by-64 tick only while the timer runs
    always_ff @(posedge clk) begin
        if (!rst_n) ref64_tick <= 1'b0;
        else        ref64_tick <= presc64_tick & tmr_en;
    end

    // Raise interrupt requests from the flags and their enables
    always_comb begin
        irq_ovf  = ovf_q & ctrl_q.ovf_ie;
        irq_edge = edge_q & ctrl_q.edge_ie;
    end

    // Drive read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADR_FLAG: begin
                bus_rdata[FLG_EDGE] = edge_q;
                bus_rdata[FLG_OVF]  = ovf_q;
            end
            ADR_CNT:  bus_rdata[CNT_W-1:0] = count_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pacc_chk.sv
// Property checker for pulse_acc_clksel, attached through bind.
module pacc_chk
    import pacc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              edge_q,
    input logic              ovf_q,
    input logic              acc_inc,
    input logic              cnt_load,
    input logic              ext8_wrap,
    input logic              presc_tick,
    input logic              tmr_tick,
    input logic              tmr_en,
    input logic              ref64_tick,
    input logic              irq_ovf
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && count_q == '0 && !edge_q && !ovf_q));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_inc && !cnt_load) |=> count_q == $past(count_q) + 1'b1);

    // R3
    edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_inc |=> edge_q);

    // R4
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_inc && !cnt_load && (&count_q)) |=> (ovf_q && count_q == '0));

    // R4
    ovf_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext8_wrap |=> ovf_q);

    // R6
    fast_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.fast_clr && bus_sel && (bus_wr || bus_rd) && bus_addr == ADR_CNT
         && !acc_inc && !ext8_wrap) |=> (!edge_q && !ovf_q));

    // R7
    irq_ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> ovf_q);

    // R9
    presc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.acc_en |-> (tmr_tick == presc_tick));

    // R11
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> !ref64_tick);
endmodule

bind pulse_acc_clksel pacc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .ctrl_q     (ctrl_q),
    .count_q    (count_q),
    .edge_q     (edge_q),
    .ovf_q      (ovf_q),
    .acc_inc    (acc_inc),
    .cnt_load   (cnt_load),
    .ext8_wrap  (ext8_wrap),
    .presc_tick (presc_tick),
    .tmr_tick   (tmr_tick),
    .tmr_en     (tmr_en),
    .ref64_tick (ref64_tick),
    .irq_ovf    (irq_ovf)
);

// File: tb/pulse_acc_clksel_tb.sv
`timescale 1ns/1ps
module pulse_acc_clksel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pulse_in = 1'b0, presc_tick = 1'b0, presc64_tick = 1'b0;
    logic        tmr_en = 1'b0, ext8_wrap = 1'b0;
    logic        tmr_tick, ref64_tick, irq_ovf, irq_edge;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int ref_cnt = 0;
    int presc_cnt = 0;
    int mism_cnt = 0;
    bit eq_mon = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_acc_clksel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_in(pulse_in), .presc_tick(presc_tick), .presc64_tick(presc64_tick),
        .tmr_en(tmr_en), .ext8_wrap(ext8_wrap), .tmr_tick(tmr_tick),
        .ref64_tick(ref64_tick), .irq_ovf(irq_ovf), .irq_edge(irq_edge)
    );

    // Count output ticks away from the clock edge
    always @(negedge clk) begin
        if (tmr_tick) tick_cnt++;
        if (ref64_tick) ref_cnt++;
        if (eq_mon && (tmr_tick !== presc_tick)) mism_cnt++;
    end

    function automatic logic [15:0] mk_ctrl(bit fast, bit en, bit rise, bit [1:0] sel, bit oie, bit eie);
        return {9'd0, fast, en, rise, sel, oie, eie};
    endfunction

    function automatic int wraps(int start, int n, int bits);
        int mask = (1 << bits) - 1;
        return ((start & mask) + n) >> bits;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic pulses(int n, bit rise);
        for (int i = 0; i < n; i++) begin
            pulse_in = rise;
            cyc(2 + $urandom % 4);
            pulse_in = ~rise;
            cyc(2 + $urandom % 4);
        end
        cyc(4);
    endtask

    // One burst under a chosen select, checked against arithmetic expectations
    task automatic run_round(bit [1:0] sel, int start, int n, bit rise, string req);
        logic [15:0] d;
        int exp_t;
        int full_w;
        wr(0, mk_ctrl(0, 0, rise, sel, 1, 1));
        pulse_in = ~rise;
        cyc(4);
        wr(2, start[15:0]);
        wr(1, 16'h0003);
        tick_cnt = 0;
        wr(0, mk_ctrl(0, 1, rise, sel, 1, 1));
        pulses(n, rise);
        full_w = wraps(start, n, 16);
        exp_t = (sel == 2'b01) ? n : (sel == 2'b10) ? wraps(start, n, 8) : full_w;
        chk(tick_cnt == exp_t, {req, " tick count"}, tick_cnt, exp_t);
        rd(2, d);
        chk(d == 16'((start + n) & 32'hFFFF), "R2 count after burst", d, (start + n) & 32'hFFFF);
        rd(1, d);
        chk(d == {14'd0, full_w > 0, n > 0}, "R3/R4 flags after burst", d, {full_w > 0, n > 0});
        chk(irq_edge == (n > 0), "R3 irq_edge", irq_edge, n > 0);
        chk(irq_ovf == (full_w > 0), "R7 irq_ovf", irq_ovf, full_w > 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1;
        cyc(1);

        // R1 reset values
        rd(0, d); chk(d == 0, "R1 ctrl reset", d, 0);
        rd(1, d); chk(d == 0, "R1 flag reset", d, 0);
        rd(2, d); chk(d == 0, "R1 count reset", d, 0);

        // R9 disabled: prescaler passes under every select; R2 edges ignored
        for (int s = 0; s < 4; s++) begin
            wr(0, mk_ctrl(0, 0, 1, s[1:0], 0, 0));
            tick_cnt = 0; presc_cnt = 0; mism_cnt = 0; eq_mon = 1;
            for (int i = 0; i < 40; i++) begin
                presc_tick = $urandom % 2;
                pulse_in = (i % 6) < 3;
                if (presc_tick) presc_cnt++;
                cyc(1);
            end
            presc_tick = 0; pulse_in = 0; cyc(4); eq_mon = 0;
            chk(mism_cnt == 0 && tick_cnt == presc_cnt, "R9 prescaler forced", tick_cnt, presc_cnt);
        end
        rd(2, d); chk(d == 0, "R2 no count while disabled", d, 0);

        // R8 select 00 with accumulator enabled
        wr(0, mk_ctrl(0, 1, 1, 2'b00, 0, 0));
        tick_cnt = 0; presc_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            presc_tick = $urandom % 2;
            if (presc_tick) presc_cnt++;
            cyc(1);
        end
        presc_tick = 0; cyc(1);
        chk(tick_cnt == presc_cnt, "R8 select 00 prescaler", tick_cnt, presc_cnt);

        // R8/R2 per-edge ticks, random polarity
        for (int r = 0; r < 6; r++)
            run_round(2'b01, $urandom % 65000, 1 + $urandom % 30, $urandom % 2, "R8 select 01");
        // R8 low byte wraps
        run_round(2'b10, 16'h00F0, 40, 1, "R8 select 10");
        for (int r = 0; r < 3; r++)
            run_round(2'b10, $urandom % 60000, 1 + $urandom % 300, $urandom % 2, "R8 select 10");
        // R8/R4 full wraps
        run_round(2'b11, 16'hFFFF, 1, 0, "R8 select 11");
        for (int r = 0; r < 3; r++)
            run_round(2'b11, 16'hFFFF - ($urandom % 16), 1 + $urandom % 24, $urandom % 2, "R8 select 11");

        // R5 write-one-to-clear (flags set from the last round)
        wr(0, mk_ctrl(0, 0, 1, 2'b01, 1, 1));
        wr(2, 16'hFFFF); wr(0, mk_ctrl(0, 1, 1, 2'b01, 1, 1));
        pulse_in = 0; cyc(2); pulses(1, 1);
        rd(1, d); chk(d == 16'h0003, "R5 upper bits zero", d, 3);
        wr(1, 16'h0000);
        rd(1, d); chk(d == 16'h0003, "R5 write 0 keeps flags", d, 3);
        wr(1, 16'h0001);
        rd(1, d); chk(d == 16'h0002, "R5 clear edge flag only", d, 2);
        chk(irq_edge == 0 && irq_ovf == 1, "R7 irq after clear", {irq_edge, irq_ovf}, 1);
        wr(0, mk_ctrl(0, 1, 1, 2'b01, 0, 1));
        chk(irq_ovf == 0, "R7 irq_ovf masked", irq_ovf, 0);
        wr(1, 16'h0002);
        rd(1, d); chk(d == 0, "R5 clear ovf flag", d, 0);

        // R4 external 8-bit wrap input
        ext8_wrap = 1; cyc(1); ext8_wrap = 0; cyc(1);
        rd(1, d); chk(d == 16'h0002, "R4 external wrap sets ovf", d, 2);

        // R6 fast clear mode
        pulses(1, 1);
        wr(0, mk_ctrl(1, 1, 1, 2'b01, 1, 1));
        wr(1, 16'h0003);
        rd(1, d); chk(d == 16'h0003, "R6 flag write ignored", d, 3);
        rd(2, d);
        rd(1, d); chk(d == 0, "R6 count read clears flags", d, 0);
        pulses(2, 1);
        ext8_wrap = 1; cyc(1); ext8_wrap = 0; cyc(1);
        wr(2, 16'h1234);
        rd(1, d); chk(d == 0, "R6 count write clears flags", d, 0);
        wr(0, mk_ctrl(0, 1, 1, 2'b01, 0, 0));
        rd(2, d); chk(d == 16'h1234, "R12 load value", d, 16'h1234);

        // R12 load meets a counted edge in the same cycle
        pulse_in = 1; cyc(2);
        wr(2, 16'h5A5A);
        pulse_in = 0; cyc(4);
        rd(2, d); chk(d == 16'h5A5A, "R12 load wins over edge", d, 16'h5A5A);

        // R10 select change acts in the next cycle
        presc_tick = 1;
        wr(0, mk_ctrl(0, 1, 1, 2'b00, 0, 0));
        @(negedge clk); chk(tmr_tick == 1, "R10 prescaler selected", tmr_tick, 1);
        #1 wr(0, mk_ctrl(0, 1, 1, 2'b01, 0, 0));
        @(negedge clk); chk(tmr_tick == 0, "R10 switched to edge source", tmr_tick, 0);
        #1 presc_tick = 0; cyc(1);

        // R11 reference tick gating
        ref_cnt = 0; tmr_en = 0;
        presc64_tick = 1; cyc(1); presc64_tick = 0; cyc(3);
        chk(ref_cnt == 0, "R11 no reference while timer off", ref_cnt, 0);
        tmr_en = 1;
        presc64_tick = 1; cyc(1); presc64_tick = 0;
        @(negedge clk); chk(ref64_tick == 1, "R11 reference one cycle later", ref64_tick, 1);
        cyc(3);
        chk(ref_cnt == 1, "R11 single reference tick", ref_cnt, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule